// File: doc/BRIEF.md
# Level Interrupt Aggregator with APB Register File

The block collects up to 64 level-sensitive interrupt request lines and folds them into a single level-sensitive request toward a parent interrupt controller. The number of lines is set by a parameter at elaboration and may be anywhere from 2 to 64. Each line has its own enable bit and its own mask bit. A line reaches the combined output only while it is high, enabled and not masked.

Software reaches the block over an APB slave port. Enable bits, mask bits and gated (final) status bits are each split into a low 32-bit word for lines 0 to 31 and a high word for lines 32 to 63. To find pending lines, software reads the final-status words and scans them for set bits. Bits for lines that are not configured have no storage. They read as zero even after software writes all ones, so software can learn the line count by writing ones and reading the value back.

Top module: `irq_aggregator_apb`

## Requirements
- R1: While reset is high, and on the first cycle after it, every enable bit and every mask bit is 0 and `irq_out` is 0.
- R2: Word offsets follow this decode: 0x00 is the enable word for lines 0–31 and 0x04 the enable word for lines 32–63. 0x08 and 0x0C are the mask words for the same two ranges. 0x30 and 0x34 are the final-status words for the same two ranges. Line n sits at bit n of the low word when n<32, and at bit n−32 of the high word otherwise. Writes to the enable and mask words read back unchanged for configured lines.
- R3: Enable, mask and status bits for line indices at or above NUM_SRC are not stored and always read 0. With NUM_SRC=40, writing 0xFFFFFFFF to the high enable word reads back as 0x000000FF.
- R4: A mask bit of 1 blocks its line and a mask bit of 0 lets it through.
- R5: Each input line is registered once. Final-status bit n is then the registered line n AND enable n AND NOT mask n.
- R6: Status is level-based. It stays set while the qualifying line stays high. Reading it does not clear it, and writes to the status offsets change nothing.
- R7: `irq_out` is a register holding the OR of all final-status bits. It goes high one cycle after a qualifying final-status bit appears, which is two clock edges after the input line rises.
- R8: Every access completes with zero wait states: `pready` is 1 and `pslverr` is 0. Reads of unmapped offsets return 0.
- R9: A line whose enable bit is 0 never sets its status bit or `irq_out`, whatever its mask bit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| irq_src | input | NUM_SRC | Level interrupt request lines |
| irq_out | output | 1 | Combined request to the parent controller |

## Verification
The assertions check on every cycle that `irq_out` follows the OR of the final status one cycle later, and that no masked line shows a status bit. They also check that bits above the configured count stay zero, that writes to the status offsets leave enable and mask untouched, and that the port never stalls or signals an error. Only the bench scenarios can show that the decoded offsets line up with the right words, that the probe value 0x000000FF appears for 40 lines, and that status levels persist across repeated reads and drop when the line falls. A behavioural model in the bench, built from plain vectors, predicts `irq_out` and every read word on every clock.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned MAX_SRC = 64;
    localparam int unsigned N_BANKS = MAX_SRC / WORD_W;
    localparam int unsigned AW      = 8;

    localparam logic [AW-1:0] OFS_EN_LO = 8'h00;
    localparam logic [AW-1:0] OFS_EN_HI = 8'h04;
    localparam logic [AW-1:0] OFS_MK_LO = 8'h08;
    localparam logic [AW-1:0] OFS_MK_HI = 8'h0C;
    localparam logic [AW-1:0] OFS_ST_LO = 8'h30;
    localparam logic [AW-1:0] OFS_ST_HI = 8'h34;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EN_LO,
        SEL_EN_HI,
        SEL_MK_LO,
        SEL_MK_HI,
        SEL_ST_LO,
        SEL_ST_HI
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        reg_sel_e          sel;
        logic [WORD_W-1:0] wdata;
    } reg_req_t;

    function automatic reg_sel_e decode_offset(logic [AW-1:0] ofs);
        case (ofs)
            OFS_EN_LO: return SEL_EN_LO;
            OFS_EN_HI: return SEL_EN_HI;
            OFS_MK_LO: return SEL_MK_LO;
            OFS_MK_HI: return SEL_MK_HI;
            OFS_ST_LO: return SEL_ST_LO;
            OFS_ST_HI: return SEL_ST_HI;
            default:   return SEL_NONE;
        endcase
    endfunction

    // Bits of one bank that correspond to configured lines
    function automatic logic [WORD_W-1:0] bank_present(int unsigned nsrc, int unsigned bank);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (bank * WORD_W + i < nsrc) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irqagg_apb_slave.sv
module irqagg_apb_slave
    import irqagg_pkg::*;
(
    input  logic                          psel,
    input  logic                          penable,
    input  logic                          pwrite,
    input  logic [AW-1:0]                 paddr,
    input  logic [WORD_W-1:0]             pwdata,
    input  logic [N_BANKS-1:0][WORD_W-1:0] en_words,
    input  logic [N_BANKS-1:0][WORD_W-1:0] mk_words,
    input  logic [N_BANKS-1:0][WORD_W-1:0] st_words,
    output reg_req_t                      req,
    output logic [WORD_W-1:0]             prdata,
    output logic                          pready,
    output logic                          pslverr
);
    reg_sel_e sel;

    assign sel       = decode_offset(paddr);
    assign req.wr    = psel & penable & pwrite;
    assign req.sel   = sel;
    assign req.wdata = pwdata;
    assign pready    = 1'b1;
    assign pslverr   = 1'b0;

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (sel)
                SEL_EN_LO: prdata = en_words[0];
                SEL_EN_HI: prdata = en_words[1];
                SEL_MK_LO: prdata = mk_words[0];
                SEL_MK_HI: prdata = mk_words[1];
                SEL_ST_LO: prdata = st_words[0];
                SEL_ST_HI: prdata = st_words[1];
                default:   prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 40,
    parameter int unsigned BANK    = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req,
    input  logic [WORD_W-1:0] src_raw,
    output logic [WORD_W-1:0] en_q,
    output logic [WORD_W-1:0] mk_q,
    output logic [WORD_W-1:0] status
);
    localparam logic [WORD_W-1:0] PRESENT = bank_present(NUM_SRC, BANK);
    localparam reg_sel_e EN_SEL = (BANK == 0) ? SEL_EN_LO : SEL_EN_HI;
    localparam reg_sel_e MK_SEL = (BANK == 0) ? SEL_MK_LO : SEL_MK_HI;

    logic [WORD_W-1:0] src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            mk_q  <= '0;
            src_q <= '0;
        end else begin
            src_q <= src_raw & PRESENT;
            if (req.wr && req.sel == EN_SEL) en_q <= req.wdata & PRESENT;
            if (req.wr && req.sel == MK_SEL) mk_q <= req.wdata & PRESENT;
        end
    end

    assign status = src_q & en_q & ~mk_q;
endmodule

// File: rtl/irqagg_combine.sv
module irqagg_combine
    import irqagg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [MAX_SRC-1:0] fstat,
    output logic               irq_q
);
    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |fstat;
    end
endmodule

// File: rtl/irq_aggregator_apb.sv
module irq_aggregator_apb
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [AW-1:0]      paddr,
    input  logic [WORD_W-1:0]  pwdata,
    output logic [WORD_W-1:0]  prdata,
    output logic               pready,
    output logic               pslverr,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic               irq_out
);
    reg_req_t                       req;
    logic [MAX_SRC-1:0]             src_full;
    logic [N_BANKS-1:0][WORD_W-1:0] en_w, mk_w, st_w;
    logic [MAX_SRC-1:0]             en_all, mask_all, fstat;

    always_comb begin
        src_full = '0;
        src_full[NUM_SRC-1:0] = irq_src;
    end

    irqagg_apb_slave u_slave (
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .en_words (en_w),
        .mk_words (mk_w),
        .st_words (st_w),
        .req      (req),
        .prdata   (prdata),
        .pready   (pready),
        .pslverr  (pslverr)
    );

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        irqagg_bank #(.NUM_SRC(NUM_SRC), .BANK(b)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .req     (req),
            .src_raw (src_full[b*WORD_W +: WORD_W]),
            .en_q    (en_w[b]),
            .mk_q    (mk_w[b]),
            .status  (st_w[b])
        );
    end

    assign en_all   = en_w;
    assign mask_all = mk_w;
    assign fstat    = st_w;

    irqagg_combine u_comb (
        .clk   (clk),
        .rst   (rst),
        .fstat (fstat),
        .irq_q (irq_out)
    );
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 40
) (
    input logic               clk,
    input logic               rst,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [AW-1:0]      paddr,
    input logic [WORD_W-1:0]  prdata,
    input logic               pready,
    input logic               pslverr,
    input logic [MAX_SRC-1:0] en_all,
    input logic [MAX_SRC-1:0] mask_all,
    input logic [MAX_SRC-1:0] fstat,
    input logic               irq_out
);
    localparam logic [MAX_SRC-1:0] CONFIGURED =
        {bank_present(NUM_SRC, 1), bank_present(NUM_SRC, 0)};

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (en_all == '0 && mask_all == '0 && !irq_out));

    p_absent_zero_r3: assert property (@(posedge clk) disable iff (rst)
        ((en_all | mask_all | fstat) & ~CONFIGURED) == '0);

    p_mask_block_r4: assert property (@(posedge clk) disable iff (rst)
        (fstat & mask_all) == '0);

    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (fstat & ~en_all) == '0);

    p_status_wr_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && pwrite && (paddr == OFS_ST_LO || paddr == OFS_ST_HI))
        |=> ($stable(en_all) && $stable(mask_all)));

    p_irq_rise_r7: assert property (@(posedge clk) disable iff (rst)
        (|fstat) |=> irq_out);

    p_irq_fall_r7: assert property (@(posedge clk) disable iff (rst)
        !(|fstat) |=> !irq_out);

    p_zero_wait_r8: assert property (@(posedge clk) disable iff (rst)
        pready && !pslverr);

    p_unmapped_read_r8: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && paddr == 8'h10) |-> prdata == '0);
endmodule

bind irq_aggregator_apb irqagg_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .prdata   (prdata),
    .pready   (pready),
    .pslverr  (pslverr),
    .en_all   (en_all),
    .mask_all (mask_all),
    .fstat    (fstat),
    .irq_out  (irq_out)
);

// File: tb/irq_aggregator_apb_tb.sv
module irq_aggregator_apb_tb;
    localparam int N = 40;
    localparam time T = 8ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]    paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic          pready, pslverr, irq_out;
    logic [N-1:0]  src = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(T/2) clk = ~clk;

    irq_aggregator_apb #(.NUM_SRC(N)) u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .irq_src(src), .irq_out(irq_out)
    );

    // Behavioural reference model
    logic [63:0] m_en, m_mk, m_src;
    logic        m_irq;
    logic [63:0] vmask;

    initial begin
        vmask = '0;
        for (int i = 0; i < N; i++) vmask[i] = 1'b1;
    end

    function automatic logic [63:0] m_stat();
        return m_src & m_en & ~m_mk;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en <= '0; m_mk <= '0; m_src <= '0; m_irq <= 1'b0;
        end else begin
            m_irq <= |m_stat();
            m_src <= {{(64-N){1'b0}}, src} & vmask;
            if (psel && penable && pwrite) begin
                case (paddr)
                    8'h00: m_en[31:0]  <= pwdata & vmask[31:0];
                    8'h04: m_en[63:32] <= pwdata & vmask[63:32];
                    8'h08: m_mk[31:0]  <= pwdata & vmask[31:0];
                    8'h0C: m_mk[63:32] <= pwdata & vmask[63:32];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_read(logic [7:0] a);
        logic [63:0] s;
        s = m_stat();
        case (a)
            8'h00: return m_en[31:0];
            8'h04: return m_en[63:32];
            8'h08: return m_mk[31:0];
            8'h0C: return m_mk[63:32];
            8'h30: return s[31:0];
            8'h34: return s[63:32];
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model (R7, R8)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R7 irq_out vs model", {31'b0, irq_out}, {31'b0, m_irq});
            check("R8 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);
        end
    end

    task automatic apb_write(logic [7:0] a, logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(logic [7:0] a, output logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk); penable = 1'b1;
        #1 d = prdata;
        @(negedge clk); psel = 1'b0; penable = 1'b0;
    endtask

    task automatic read_check(string req, logic [7:0] a, logic [31:0] exp);
        logic [31:0] d;
        apb_read(a, d);
        check(req, d, exp);
    endtask

    task automatic read_model(string req, logic [7:0] a);
        logic [31:0] d, e;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk); penable = 1'b1;
        #1 d = prdata; e = exp_read(a);
        @(negedge clk); psel = 1'b0; penable = 1'b0;
        check(req, d, e);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(T * 100000);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d1, d2;
        repeat (3) @(negedge clk);
        check("R1 irq_out in reset", {31'b0, irq_out}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 irq_out after reset", {31'b0, irq_out}, 32'h0);
        read_check("R1 enable lo reset", 8'h00, 32'h0);
        read_check("R1 enable hi reset", 8'h04, 32'h0);
        read_check("R1 mask lo reset", 8'h08, 32'h0);
        read_check("R1 mask hi reset", 8'h0C, 32'h0);

        // Probing: write all ones, read back (R2, R3)
        apb_write(8'h00, 32'hFFFF_FFFF);
        apb_write(8'h04, 32'hFFFF_FFFF);
        apb_write(8'h08, 32'hFFFF_FFFF);
        apb_write(8'h0C, 32'hFFFF_FFFF);
        read_check("R2 enable lo readback", 8'h00, 32'hFFFF_FFFF);
        read_check("R3 enable hi probe", 8'h04, 32'h0000_00FF);
        read_check("R2 mask lo readback", 8'h08, 32'hFFFF_FFFF);
        read_check("R3 mask hi probe", 8'h0C, 32'h0000_00FF);
        apb_write(8'h08, 32'h0);
        apb_write(8'h0C, 32'h0);
        apb_write(8'h00, 32'h0000_000F);
        apb_write(8'h04, 32'h0000_0080);
        read_check("R2 enable lo pattern", 8'h00, 32'h0000_000F);
        read_check("R2 enable hi pattern", 8'h04, 32'h0000_0080);

        // R7 latency: line 0 rises; irq two edges later
        src[0] = 1'b1;
        @(negedge clk);
        check("R7 irq not yet high", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        check("R7 irq high after one cycle", {31'b0, irq_out}, 32'h1);
        src[0] = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 irq low after line drops", {31'b0, irq_out}, 32'h0);

        // R5 status placement in both words
        src[1] = 1'b1; src[39] = 1'b1;
        repeat (2) @(negedge clk);
        read_check("R5 status lo bit1", 8'h30, 32'h0000_0002);
        read_check("R5 status hi bit7 (line 39)", 8'h34, 32'h0000_0080);

        // R6 level hold, no clear on read, status writes ignored
        apb_read(8'h30, d1);
        apb_read(8'h30, d2);
        check("R6 status persists over reads", d2, d1);
        apb_write(8'h30, 32'hFFFF_FFFF);
        apb_write(8'h34, 32'hFFFF_FFFF);
        read_check("R6 status unchanged by write", 8'h30, 32'h0000_0002);
        read_check("R6 enable unaffected by status write", 8'h00, 32'h0000_000F);
        read_check("R6 mask unaffected by status write", 8'h08, 32'h0);

        // R4 masking
        apb_write(8'h08, 32'h0000_0002);
        read_check("R4 masked line gives no status", 8'h30, 32'h0);
        check("R4 unmasked hi line keeps irq", {31'b0, irq_out}, 32'h1);
        apb_write(8'h0C, 32'h0000_0080);
        @(negedge clk);
        read_check("R4 masked hi status", 8'h34, 32'h0);
        check("R4 all masked irq low", {31'b0, irq_out}, 32'h0);
        apb_write(8'h08, 32'h0);
        @(negedge clk);
        check("R4 unmask restores irq", {31'b0, irq_out}, 32'h1);

        // R9 disabled line
        src[1] = 1'b0; src[39] = 1'b0; src[5] = 1'b1;
        repeat (3) @(negedge clk);
        read_check("R9 disabled line no status", 8'h30, 32'h0);
        check("R9 disabled line no irq", {31'b0, irq_out}, 32'h0);

        // R8 unmapped reads
        read_check("R8 unmapped 0x10", 8'h10, 32'h0);
        read_check("R8 unmapped 0x2C", 8'h2C, 32'h0);
        read_check("R8 unmapped 0x38", 8'h38, 32'h0);

        // R5 sweep of patterns against the model
        for (int k = 0; k < 20; k++) begin
            src = N'({$urandom, $urandom});
            apb_write(8'h00, $urandom);
            apb_write(8'h04, $urandom);
            apb_write(8'h08, $urandom);
            @(negedge clk);
            read_model("R5 status lo sweep", 8'h30);
            read_model("R5 status hi sweep", 8'h34);
        end

        // R1 reset again clears everything
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        src = '0;
        @(negedge clk);
        read_check("R1 enable lo after reset", 8'h00, 32'h0);
        read_check("R1 mask hi after reset", 8'h0C, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule